// File: doc/BRIEF.md
# Mixed-Radix Bus Cycle Timer

This block keeps bus time as one 32-bit word made of three packed fields. The lowest 12 bits hold a sub-cycle offset that counts reference ticks and wraps after 3072. The next 13 bits hold a cycle count that wraps after 8000. The top 7 bits hold a seconds count that wraps after 128. The timer advances by one reference tick on each clock edge where the tick enable is high, and each field carries into the one above it on the same edge.

A host can load a new value into the whole word with a write strobe. A field value that is out of range is clamped to that field's largest legal value. A read strobe captures all 32 bits from a single edge into a held read register, so the fields in a read can never come from different edges. Each tick that returns the offset to zero also raises a one-cycle cycle-start pulse.

Top module: `ct_cycle_timer`

## Requirements
- R1: After reset all three fields are zero, and `rd_valid` and `cyc_start` are low.
- R2: The offset field (bits 11:0) increments on each clock edge where `tick_en` is high. After 3071 it returns to 0.
- R3: The cycle count field (bits 24:12) increments on the same edge where the offset wraps, with no lag. After 7999 it returns to 0.
- R4: The seconds field (bits 31:25) increments on the edge where the cycle count wraps. After 127 it returns to 0, and no other output changes.
- R5: When `tick_en` is low and no write occurs, the timer value does not change.
- R6: When `wr_en` is high at an edge, all three fields load from `wr_data` on that edge. This load takes precedence over a tick in the same cycle.
- R7: On a load, an offset of 3072 or more is stored as 3071, and a cycle count of 8000 or more is stored as 7999.
- R8: `rd_en` high at an edge makes `rd_valid` high in the next cycle. In that cycle `rd_data` holds the full timer value that was present just before the edge. `rd_valid` is low in cycles that follow an edge where `rd_en` was low.
- R9: `cyc_start` is high for exactly the one cycle that follows an edge where a tick wrapped the offset from 3071 to 0. A load never raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Advance the timer by one reference tick on this edge |
| wr_en | input | 1 | Load strobe |
| wr_data | input | 32 | Value to load: {seconds, cycle count, offset} |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Captured timer value |
| rd_valid | output | 1 | `rd_data` was captured on the previous edge |
| cyc_start | output | 1 | One-cycle pulse after the offset wraps |

## Verification
The bench loads values just below each wrap point and ticks across them. A design that delayed the carry would show an offset of 0 paired with the old cycle count. A design that wrapped at the power of two would show 3072 or 8000 in a field. The seconds wrap from 127 is checked to land on a clean zero. The bench loads out-of-range fields to catch a missing clamp. It asserts a load and a tick together to catch a tick that overrides the load. It asserts a read and a tick together to catch a snapshot that returns the post-tick value.

// File: rtl/ct_pkg.sv
package ct_pkg;
   localparam int unsigned CT_OFF_W   = 12;
   localparam int unsigned CT_OFF_MOD = 3072;
   localparam int unsigned CT_CNT_W   = 13;
   localparam int unsigned CT_CNT_MOD = 8000;
   localparam int unsigned CT_SEC_W   = 7;
endpackage

// File: rtl/ct_field.sv
module ct_field #(
   parameter int unsigned W   = 12,
   parameter int unsigned MOD = 3072
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   input  logic         ld,
   input  logic [W-1:0] ld_val,
   output logic [W-1:0] val,
   output logic         wrap
);
   localparam logic [W-1:0] LAST = W'(MOD - 1);
   localparam bit POW2 = (MOD == (64'd1 << W));

   assign wrap = inc && (val == LAST);

   generate
      if (POW2) begin : g_pow2
         always_ff @(posedge clk) begin
            if (!rst_n)   val <= '0;
            else if (ld)  val <= ld_val;
            else if (inc) val <= val + 1'b1;
         end
      end else begin : g_mod
         logic [W-1:0] ld_clamped;
         assign ld_clamped = (ld_val > LAST) ? LAST : ld_val;
         always_ff @(posedge clk) begin
            if (!rst_n)   val <= '0;
            else if (ld)  val <= ld_clamped;
            else if (inc) val <= (val == LAST) ? '0 : val + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/ct_snapshot.sv
module ct_snapshot #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cap,
   input  logic [W-1:0] src,
   output logic [W-1:0] held,
   output logic         valid
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held  <= '0;
         valid <= 1'b0;
      end else begin
         valid <= cap;
         if (cap) held <= src;
      end
   end
endmodule

// File: rtl/ct_cycle_timer.sv
module ct_cycle_timer
   import ct_pkg::*;
#(
   parameter int unsigned OFF_W   = CT_OFF_W,
   parameter int unsigned OFF_MOD = CT_OFF_MOD,
   parameter int unsigned CNT_W   = CT_CNT_W,
   parameter int unsigned CNT_MOD = CT_CNT_MOD,
   parameter int unsigned SEC_W   = CT_SEC_W,
   localparam int unsigned TW     = OFF_W + CNT_W + SEC_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick_en,
   input  logic          wr_en,
   input  logic [TW-1:0] wr_data,
   input  logic          rd_en,
   output logic [TW-1:0] rd_data,
   output logic          rd_valid,
   output logic          cyc_start
);
   localparam int unsigned CNT_LO = OFF_W;
   localparam int unsigned SEC_LO = OFF_W + CNT_W;

   generate
      if (OFF_MOD < 2 || OFF_MOD > (64'd1 << OFF_W)) begin : g_bad_off
         $error("OFF_MOD does not fit OFF_W");
      end
      if (CNT_MOD < 2 || CNT_MOD > (64'd1 << CNT_W)) begin : g_bad_cnt
         $error("CNT_MOD does not fit CNT_W");
      end
   endgenerate

   logic [OFF_W-1:0] off_q;
   logic [CNT_W-1:0] cnt_q;
   logic [SEC_W-1:0] sec_q;
   logic             off_wrap, cnt_wrap, sec_wrap;
   logic             adv;
   logic [TW-1:0]    cur;

   assign adv = tick_en && !wr_en;
   assign cur = {sec_q, cnt_q, off_q};

   ct_field #(.W(OFF_W), .MOD(OFF_MOD)) u_off (
      .clk(clk), .rst_n(rst_n), .inc(adv), .ld(wr_en),
      .ld_val(wr_data[OFF_W-1:0]), .val(off_q), .wrap(off_wrap));

   ct_field #(.W(CNT_W), .MOD(CNT_MOD)) u_cnt (
      .clk(clk), .rst_n(rst_n), .inc(off_wrap), .ld(wr_en),
      .ld_val(wr_data[SEC_LO-1:CNT_LO]), .val(cnt_q), .wrap(cnt_wrap));

   ct_field #(.W(SEC_W), .MOD(64'd1 << SEC_W)) u_sec (
      .clk(clk), .rst_n(rst_n), .inc(cnt_wrap), .ld(wr_en),
      .ld_val(wr_data[TW-1:SEC_LO]), .val(sec_q), .wrap(sec_wrap));

   ct_snapshot #(.W(TW)) u_snap (
      .clk(clk), .rst_n(rst_n), .cap(rd_en), .src(cur),
      .held(rd_data), .valid(rd_valid));

   always_ff @(posedge clk) begin
      if (!rst_n) cyc_start <= 1'b0;
      else        cyc_start <= off_wrap;
   end

   logic unused_sec_wrap;
   assign unused_sec_wrap = sec_wrap;
endmodule

// File: rtl/ct_cycle_timer_chk.sv
module ct_cycle_timer_chk #(
   parameter int unsigned OFF_W   = 12,
   parameter int unsigned OFF_MOD = 3072,
   parameter int unsigned CNT_W   = 13,
   parameter int unsigned CNT_MOD = 8000,
   parameter int unsigned SEC_W   = 7,
   localparam int unsigned TW     = OFF_W + CNT_W + SEC_W
) (
   input logic          clk,
   input logic          rst_n,
   input logic          tick_en,
   input logic          wr_en,
   input logic [TW-1:0] wr_data,
   input logic          rd_en,
   input logic [TW-1:0] rd_data,
   input logic          rd_valid,
   input logic          cyc_start,
   input logic [TW-1:0] cur
);
   localparam logic [OFF_W-1:0] OFF_LAST = OFF_W'(OFF_MOD - 1);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CNT_MOD - 1);

   logic [OFF_W-1:0] c_off;
   logic [CNT_W-1:0] c_cnt;
   logic [OFF_W-1:0] w_off;
   logic [CNT_W-1:0] w_cnt;
   assign c_off = cur[OFF_W-1:0];
   assign c_cnt = cur[OFF_W+CNT_W-1:OFF_W];
   assign w_off = wr_data[OFF_W-1:0];
   assign w_cnt = wr_data[OFF_W+CNT_W-1:OFF_W];

   // R2
   off_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      c_off <= OFF_LAST);

   // R3
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      c_cnt <= CNT_LAST);

   // R3
   carry_same_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_en && !wr_en && c_off == OFF_LAST) |=>
      (c_off == '0 && c_cnt == (($past(c_cnt) == CNT_LAST) ? '0 : $past(c_cnt) + 1'b1)));

   // R5
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_en && !wr_en) |=> $stable(cur));

   // R6
   load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && w_off <= OFF_LAST && w_cnt <= CNT_LAST) |=> cur == $past(wr_data));

   // R8
   snapshot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> (rd_valid && rd_data == $past(cur)));

   // R9
   pulse_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_start |-> (c_off == '0 && !$past(wr_en)));
endmodule

bind ct_cycle_timer ct_cycle_timer_chk #(
   .OFF_W(OFF_W), .OFF_MOD(OFF_MOD), .CNT_W(CNT_W), .CNT_MOD(CNT_MOD), .SEC_W(SEC_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .wr_data(wr_data),
   .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid), .cyc_start(cyc_start),
   .cur(cur)
);

// File: tb/ct_cycle_timer_bench.sv
module ct_cycle_timer_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic        rd_en = 1'b0;
   logic [31:0] rd_data;
   logic        rd_valid;
   logic        cyc_start;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   ct_cycle_timer u_ct_cycle_timer (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .wr_data(wr_data),
      .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid), .cyc_start(cyc_start));

   typedef struct packed {
      int wsec; int wcnt; int woff; int ticks;
      int esec; int ecnt; int eoff;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VEC [NV] = '{
      '{0,    0,    0,    5,    0,   0,    5},     // R2 plain count
      '{0,    0, 3071,    1,    0,   1,    0},     // R3 carry on wrap
      '{3, 7999, 3071,    1,    4,   0,    0},     // R4 seconds carry
      '{127,7999, 3071,   1,    0,   0,    0},     // R4 seconds wrap
      '{2,   10, 3070,    3,    2,  11,    1},     // R2 R3 across wrap
      '{5, 8191, 4095,    0,    5,7999, 3071},     // R7 both clamped
      '{1, 8000, 3000,    0,    1,7999, 3000},     // R7 count clamp edge
      '{9, 7999, 3071, 3073,   10,   1,    0}      // R3 R4 long run
   };

   function automatic logic [31:0] pack(int s, int c, int o);
      return {s[6:0], c[12:0], o[11:0]};
   endfunction

   task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_write(logic [31:0] v);
      @(negedge clk); wr_en = 1'b1; wr_data = v;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic do_ticks(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick_en = 1'b1;
      end
      @(negedge clk); tick_en = 1'b0;
   endtask

   task automatic do_read(logic [31:0] exp, string req);
      @(negedge clk); rd_en = 1'b1;
      @(negedge clk); rd_en = 1'b0;
      chk(rd_valid && rd_data == exp, req, rd_data, exp);
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         checks++; failures++;
         $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      int pulses;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(!rd_valid && !cyc_start, "R1", {30'd0, rd_valid, cyc_start}, 32'h0);
      do_read(32'h0, "R1");
      @(negedge clk);
      chk(!rd_valid, "R8", {31'd0, rd_valid}, 32'h0);

      foreach (VEC[k]) begin
         do_write(pack(VEC[k].wsec, VEC[k].wcnt, VEC[k].woff));
         if (VEC[k].ticks > 0) do_ticks(VEC[k].ticks);
         do_read(pack(VEC[k].esec, VEC[k].ecnt, VEC[k].eoff), "R2/R3/R4/R7 vector");
      end

      // R5 idle hold
      do_write(pack(7, 123, 456));
      repeat (10) @(negedge clk);
      do_read(pack(7, 123, 456), "R5");

      // R6 load with tick in same cycle
      @(negedge clk); wr_en = 1'b1; tick_en = 1'b1; wr_data = pack(1, 2, 100);
      @(negedge clk); wr_en = 1'b0; tick_en = 1'b0;
      do_read(pack(1, 2, 100), "R6");

      // R8 read with tick on same edge returns pre-tick value
      @(negedge clk); rd_en = 1'b1; tick_en = 1'b1;
      @(negedge clk); rd_en = 1'b0; tick_en = 1'b0;
      chk(rd_valid && rd_data == pack(1, 2, 100), "R8", rd_data, pack(1, 2, 100));
      do_read(pack(1, 2, 101), "R8");

      // R9 pulse placement
      do_write(pack(0, 0, 3069));
      @(negedge clk); tick_en = 1'b1;
      @(negedge clk); tick_en = 1'b0;
      chk(!cyc_start, "R9", {31'd0, cyc_start}, 32'h0);
      do_write(pack(0, 0, 3071));
      chk(!cyc_start, "R9 load", {31'd0, cyc_start}, 32'h0);
      @(negedge clk); tick_en = 1'b1;
      @(negedge clk); tick_en = 1'b0;
      chk(cyc_start, "R9", {31'd0, cyc_start}, 32'h1);
      @(negedge clk);
      chk(!cyc_start, "R9 width", {31'd0, cyc_start}, 32'h0);

      // R9 pulse count over two cycles of ticks
      do_write(pack(0, 0, 0));
      pulses = 0;
      @(negedge clk); tick_en = 1'b1;
      for (int i = 0; i < 2 * 3072; i++) begin
         @(negedge clk);
         if (cyc_start) pulses++;
      end
      tick_en = 1'b0;
      @(negedge clk);
      if (cyc_start) pulses++;
      chk(pulses == 2, "R9 count", 32'(pulses), 32'd2);

      // R1 reset clears a loaded value
      do_write(pack(50, 500, 50));
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      do_read(32'h0, "R1");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule